// File: doc/BRIEF.md
# Phase-Frequency Detector with Hysteretic Lock Indicator

This block sits between the two programmable dividers of a frequency synthesizer and the charge pump. It takes the divided reference pulse and the divided oscillator pulse, both synchronous to the reference-oscillator clock. A three-state detector turns the time between their rising edges into up and down pump enables. It also produces a three-valued pump drive code and a pair of phase outputs for an external pump. One polarity input turns every one of these around, so that loop filters and oscillators with either tuning slope can be served.

A lock indicator measures each error pulse in oscillator clock cycles. A long pulse clears it at once. It is set again only after several comparisons in a row that stay within a short bound, so it does not chatter near the threshold. A monitor output shows either the lock indicator or one of the divided pulses. A power-save input clears the detector, floats the pump and holds the lock indicator high. A force-off input floats the pump by itself. After a power-save exit, the first error pulse that reaches the pump is clipped to a bounded length, which prevents a large frequency step. A pump current-select bit is passed through unchanged.

Top module: `pfd_lock_top`

## Requirements
- R1: When one input rises k oscillator cycles before the other (k >= 0), the pump enable for the leading input is active alone for exactly k cycles. Simultaneous edges give no lone enable.
- R2: Each comparison ends with exactly one cycle in which both enables are active. Both are inactive in the following cycle. This gives pump pulses with no dead zone even at zero phase error.
- R3: The drive code cp_code is 2'b10 to drive high, 2'b01 to drive low and 2'b00 for high impedance; 2'b11 never appears. With pol=1 a leading reference drives high and a leading oscillator pulse drives low. With pol=0 these are swapped. Equal edges give 2'b00.
- R4: up_en is active exactly in the cycles where the drive code is high, and dn_en exactly where it is low (the polarity swap applies to the enables as well).
- R5: phr is 1 and php_pull is 1 (pulling low, else floating) exactly in the cycles where the detector asks to drive high. Both are independent of zc_n.
- R6: While zc_n=0, cp_code is 2'b00 and both enables are 0.
- R7: While ps_n=0, the detector is cleared, cp_code is 2'b00, phr is 0 and lock_o is 1 from the same cycle on.
- R8: After ps_n returns to 1, the first error pulse drives the pump for at most START_MAX (default 3) cycles. Later pulses are not clipped.
- R9: When one error pulse reaches UNLOCK_CYC (default 4) cycles, lock_o is 0 from the next cycle.
- R10: lock_o is set only after LOCK_RUNS (default 3) consecutive comparisons whose error is at most LOCK_CYC (default 2) cycles. A comparison with an error between the two bounds does not clear lock_o, but it restarts the count.
- R11: With mon_sel=1, mon_out follows ref_in when pol=1 and vco_in when pol=0. With mon_sel=0, mon_out equals lock_o.
- R12: After reset, lock_o is 0, both enables are 0 and cp_code is 2'b00.
- R13: cur_sel_o always equals cur_sel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference-oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_in | input | 1 | Divided reference pulse |
| vco_in | input | 1 | Divided oscillator pulse |
| pol | input | 1 | Polarity select (1 = reference lead drives high) |
| mon_sel | input | 1 | Monitor select (1 = divided pulse, 0 = lock) |
| ps_n | input | 1 | 0 = power save |
| zc_n | input | 1 | 0 = force pump to high impedance |
| cur_sel | input | 1 | Pump current select |
| up_en | output | 1 | Pump source enable |
| dn_en | output | 1 | Pump sink enable |
| cp_code | output | 2 | Pump drive code (high, low, high impedance) |
| phr | output | 1 | Push-pull phase output |
| php_pull | output | 1 | Open-drain phase output, 1 = pull low |
| mon_out | output | 1 | Monitor output |
| lock_o | output | 1 | Lock indicator |
| cur_sel_o | output | 1 | Pump current select, passed through |

## Verification
The assertions check on every cycle the properties that are local in time. Each overlap cycle is followed by an idle cycle, the unused drive code never appears, and force-off and power save override the pump. A long error pulse always clears lock in the next cycle, lock is only set at the end of a comparison, and the start-up clip floats the pump. The bench's scenarios cover the behaviour that spans many cycles. This includes the exact pulse widths for both polarities and several lead and lag amounts, and the count of three good comparisons with its restart after a mid-range error. It also covers the hold of lock through that error, the single clipped pulse after a power-save exit and the monitor selection.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
    typedef enum logic [1:0] {
        CP_HIZ  = 2'b00,
        CP_LOW  = 2'b01,
        CP_HIGH = 2'b10
    } cp_code_e;
endpackage

// File: rtl/pfd_detector.sv
module pfd_detector #(
    parameter int RUN_MAX = 5,
    parameter int RUN_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_in,
    input  logic             vco_in,
    input  logic             ps_n,
    output logic             up_o,
    output logic             dn_o,
    output logic             both_o,
    output logic [RUN_W-1:0] run_o,
    output logic             lim_o
);
    typedef struct packed {
        logic             ref_prev;
        logic             vco_prev;
        logic             up;
        logic             dn;
        logic [RUN_W-1:0] run;
        logic             lim;
    } det_s;

    det_s q, d;
    logic ref_rise, vco_rise, err;
    logic [RUN_W-1:0] run_now;

    always_comb begin
        d        = q;
        ref_rise = ref_in & ~q.ref_prev;
        vco_rise = vco_in & ~q.vco_prev;
        d.ref_prev = ref_in;
        d.vco_prev = vco_in;
        if (q.up && q.dn) begin
            d.up = 1'b0;
            d.dn = 1'b0;
        end else begin
            d.up = q.up | ref_rise;
            d.dn = q.dn | vco_rise;
        end
        err = q.up ^ q.dn;
        if (!err)
            run_now = '0;
        else if (q.run == RUN_W'(RUN_MAX))
            run_now = q.run;
        else
            run_now = q.run + RUN_W'(1);
        d.run = run_now;
        if (q.lim && q.up && q.dn)
            d.lim = 1'b0;
        if (!ps_n) begin
            d.up  = 1'b0;
            d.dn  = 1'b0;
            d.run = '0;
            d.lim = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign up_o   = q.up;
    assign dn_o   = q.dn;
    assign both_o = q.up & q.dn;
    assign run_o  = run_now;
    assign lim_o  = q.lim;
endmodule

// File: rtl/pfd_lockdet.sv
module pfd_lockdet #(
    parameter int LOCK_CYC   = 2,
    parameter int UNLOCK_CYC = 4,
    parameter int LOCK_RUNS  = 3,
    parameter int RUN_W      = 3,
    localparam int GW        = $clog2(LOCK_RUNS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [RUN_W-1:0] run_i,
    input  logic             both_i,
    input  logic             ps_n,
    output logic             lock_o
);
    typedef struct packed {
        logic [RUN_W-1:0] worst;
        logic [GW-1:0]    good;
        logic             lock;
    } ld_s;

    ld_s q, d;

    always_comb begin
        d = q;
        if (run_i > q.worst)
            d.worst = run_i;
        if (both_i) begin
            d.worst = '0;
            if (int'(q.worst) <= LOCK_CYC) begin
                if (int'(q.good) < LOCK_RUNS)
                    d.good = q.good + GW'(1);
                if (int'(q.good) + 1 >= LOCK_RUNS)
                    d.lock = 1'b1;
            end else begin
                d.good = '0;
            end
        end
        if (int'(run_i) >= UNLOCK_CYC) begin
            d.lock = 1'b0;
            d.good = '0;
        end
        if (!ps_n) begin
            d.lock  = 1'b1;
            d.good  = '0;
            d.worst = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign lock_o = q.lock;

    // R9: a long error pulse clears lock in the next cycle
    a_r9_unlock_on_long_error: assert property (@(posedge clk) disable iff (!rst_n)
        (ps_n && int'(run_i) >= UNLOCK_CYC) |=> !q.lock);

    // R10: lock is set only at the end of a comparison or by power save
    a_r10_lock_at_compare: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.lock) |-> ($past(both_i) || !$past(ps_n)));
endmodule

// File: rtl/pfd_outstage.sv
module pfd_outstage
    import pfd_pkg::*;
#(
    parameter int START_MAX = 3,
    parameter int RUN_W     = 3
) (
    input  logic             up_i,
    input  logic             dn_i,
    input  logic [RUN_W-1:0] run_i,
    input  logic             lim_i,
    input  logic             lock_i,
    input  logic             pol,
    input  logic             ps_n,
    input  logic             zc_n,
    input  logic             mon_sel,
    input  logic             ref_in,
    input  logic             vco_in,
    output logic             up_en,
    output logic             dn_en,
    output logic [1:0]       cp_code,
    output logic             phr,
    output logic             php_pull,
    output logic             lock_o,
    output logic             mon_out
);
    logic clip, pu, pd, hi_c, lo_c, off;

    always_comb begin
        clip = lim_i && (int'(run_i) > START_MAX);
        pu   = up_i & ~clip;
        pd   = dn_i & ~clip;
        hi_c = pol ? (pu & ~pd) : (pd & ~pu);
        lo_c = pol ? (pd & ~pu) : (pu & ~pd);
        off  = !ps_n || !zc_n;
        if (off)       cp_code = CP_HIZ;
        else if (hi_c) cp_code = CP_HIGH;
        else if (lo_c) cp_code = CP_LOW;
        else           cp_code = CP_HIZ;
        up_en    = !off && (pol ? pu : pd);
        dn_en    = !off && (pol ? pd : pu);
        phr      = ps_n && hi_c;
        php_pull = ps_n && hi_c;
        lock_o   = lock_i || !ps_n;
        mon_out  = mon_sel ? (pol ? ref_in : vco_in) : lock_o;
    end
endmodule

// File: rtl/pfd_lock_top.sv
module pfd_lock_top #(
    parameter int LOCK_CYC   = 2,
    parameter int UNLOCK_CYC = 4,
    parameter int LOCK_RUNS  = 3,
    parameter int START_MAX  = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_in,
    input  logic       vco_in,
    input  logic       pol,
    input  logic       mon_sel,
    input  logic       ps_n,
    input  logic       zc_n,
    input  logic       cur_sel,
    output logic       up_en,
    output logic       dn_en,
    output logic [1:0] cp_code,
    output logic       phr,
    output logic       php_pull,
    output logic       mon_out,
    output logic       lock_o,
    output logic       cur_sel_o
);
    localparam int RUN_MAX = ((UNLOCK_CYC > START_MAX) ? UNLOCK_CYC : START_MAX) + 1;
    localparam int RUN_W   = $clog2(RUN_MAX + 1);

    logic             det_up, det_dn, det_both, det_lim, lock_q;
    logic [RUN_W-1:0] det_run;

    pfd_detector #(.RUN_MAX(RUN_MAX), .RUN_W(RUN_W)) u_det (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .vco_in(vco_in), .ps_n(ps_n),
        .up_o(det_up), .dn_o(det_dn), .both_o(det_both), .run_o(det_run), .lim_o(det_lim)
    );

    pfd_lockdet #(.LOCK_CYC(LOCK_CYC), .UNLOCK_CYC(UNLOCK_CYC),
                  .LOCK_RUNS(LOCK_RUNS), .RUN_W(RUN_W)) u_lock (
        .clk(clk), .rst_n(rst_n), .run_i(det_run), .both_i(det_both),
        .ps_n(ps_n), .lock_o(lock_q)
    );

    pfd_outstage #(.START_MAX(START_MAX), .RUN_W(RUN_W)) u_out (
        .up_i(det_up), .dn_i(det_dn), .run_i(det_run), .lim_i(det_lim), .lock_i(lock_q),
        .pol(pol), .ps_n(ps_n), .zc_n(zc_n), .mon_sel(mon_sel),
        .ref_in(ref_in), .vco_in(vco_in),
        .up_en(up_en), .dn_en(dn_en), .cp_code(cp_code), .phr(phr),
        .php_pull(php_pull), .lock_o(lock_o), .mon_out(mon_out)
    );

    assign cur_sel_o = cur_sel;

    // R2: overlap lasts one cycle, then the pump is idle
    a_r2_overlap_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (up_en && dn_en) |=> (!up_en && !dn_en));

    // R3: the unused code never appears
    a_r3_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        cp_code != 2'b11);

    // R6: force-off floats the pump
    a_r6_force_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        !zc_n |-> (cp_code == 2'b00 && !up_en && !dn_en));

    // R7: power save floats the pump and holds lock
    a_r7_powersave: assert property (@(posedge clk) disable iff (!rst_n)
        !ps_n |-> (lock_o && cp_code == 2'b00 && !phr));

    // R8: a start-up pulse beyond its limit does not reach the pump
    a_r8_start_clip: assert property (@(posedge clk) disable iff (!rst_n)
        (det_lim && int'(det_run) > START_MAX) |-> (cp_code == 2'b00 && !up_en && !dn_en));
endmodule

// File: tb/tb_pfd_lock_top.sv
module tb_pfd_lock_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_in = 1'b0, vco_in = 1'b0, pol = 1'b1, mon_sel = 1'b0;
    logic ps_n = 1'b1, zc_n = 1'b1, cur_sel = 1'b0;
    logic up_en, dn_en, phr, php_pull, mon_out, lock_o, cur_sel_o;
    logic [1:0] cp_code;

    int checks = 0, failures = 0;
    int hi_c, lo_c, up_c, dn_c, both_c, phr_c, php_c;

    pfd_lock_top dut (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .vco_in(vco_in), .pol(pol),
        .mon_sel(mon_sel), .ps_n(ps_n), .zc_n(zc_n), .cur_sel(cur_sel),
        .up_en(up_en), .dn_en(dn_en), .cp_code(cp_code), .phr(phr),
        .php_pull(php_pull), .mon_out(mon_out), .lock_o(lock_o), .cur_sel_o(cur_sel_o)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic reset_dut();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // delta > 0: reference rises delta cycles before the oscillator pulse
    task automatic run_pair(input int delta);
        int a, ref_at, vco_at;
        a = (delta < 0) ? -delta : delta;
        ref_at = (delta < 0) ? a : 0;
        vco_at = (delta > 0) ? a : 0;
        hi_c = 0; lo_c = 0; up_c = 0; dn_c = 0; both_c = 0; phr_c = 0; php_c = 0;
        for (int c = 0; c < a + 6; c++) begin
            @(negedge clk);
            if (cp_code == 2'b10) hi_c++;
            if (cp_code == 2'b01) lo_c++;
            if (up_en && !dn_en) up_c++;
            if (dn_en && !up_en) dn_c++;
            if (up_en && dn_en) both_c++;
            if (phr) phr_c++;
            if (php_pull) php_c++;
            ref_in = (c == ref_at);
            vco_in = (c == vco_at);
        end
        @(negedge clk);
        ref_in = 1'b0;
        vco_in = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // {pol, delta, expected high cycles, expected low cycles}
    localparam int NV = 8;
    localparam int VEC [NV][4] = '{
        '{1,  3, 3, 0},
        '{1, -2, 0, 2},
        '{1,  0, 0, 0},
        '{0,  3, 0, 3},
        '{0, -5, 5, 0},
        '{1,  7, 7, 0},
        '{0,  1, 0, 1},
        '{1, -1, 0, 1}
    };

    initial begin
        #(20 * 100000);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        reset_dut();
        // R12 reset state
        check(lock_o == 1'b0, "R12 lock after reset", lock_o, 0);
        check(!up_en && !dn_en, "R12 enables after reset", up_en | dn_en, 0);
        check(cp_code == 2'b00, "R12 code after reset", cp_code, 0);
        // R13 pass-through
        cur_sel = 1'b1; #1;
        check(cur_sel_o == 1'b1, "R13 current select high", cur_sel_o, 1);
        cur_sel = 1'b0; #1;
        check(cur_sel_o == 1'b0, "R13 current select low", cur_sel_o, 0);

        // vector table: R1 R2 R3 R4 R5
        for (int i = 0; i < NV; i++) begin
            pol = VEC[i][0][0];
            run_pair(VEC[i][1]);
            check(hi_c == VEC[i][2], $sformatf("R3 high cycles vec%0d", i), hi_c, VEC[i][2]);
            check(lo_c == VEC[i][3], $sformatf("R3 low cycles vec%0d", i), lo_c, VEC[i][3]);
            check(up_c == VEC[i][2], $sformatf("R4 up_en cycles vec%0d", i), up_c, VEC[i][2]);
            check(dn_c == VEC[i][3], $sformatf("R1 R4 dn_en cycles vec%0d", i), dn_c, VEC[i][3]);
            check(both_c == 1, $sformatf("R2 overlap cycles vec%0d", i), both_c, 1);
            check(phr_c == VEC[i][2], $sformatf("R5 phr cycles vec%0d", i), phr_c, VEC[i][2]);
            check(php_c == VEC[i][2], $sformatf("R5 php_pull cycles vec%0d", i), php_c, VEC[i][2]);
        end

        // lock acquisition and hysteresis: R10 R9
        reset_dut();
        pol = 1'b1;
        run_pair(1); run_pair(1);
        check(lock_o == 1'b0, "R10 not locked after two good", lock_o, 0);
        run_pair(1);
        check(lock_o == 1'b1, "R10 locked after three good", lock_o, 1);
        run_pair(3);
        check(lock_o == 1'b1, "R10 lock held through mid error", lock_o, 1);
        run_pair(4);
        check(lock_o == 1'b0, "R9 lock dropped by long error", lock_o, 0);
        run_pair(3); run_pair(1); run_pair(1);
        check(lock_o == 1'b0, "R10 count restarted by mid error", lock_o, 0);
        run_pair(1);
        check(lock_o == 1'b1, "R10 relocked", lock_o, 1);

        // monitor: R11 (changes within one low phase, no clock edge between)
        @(negedge clk);
        mon_sel = 1'b1; pol = 1'b1; ref_in = 1'b1; vco_in = 1'b0; #1;
        check(mon_out == 1'b1, "R11 monitor ref pol1", mon_out, 1);
        pol = 1'b0; #1;
        check(mon_out == 1'b0, "R11 monitor vco pol0", mon_out, 0);
        ref_in = 1'b0; vco_in = 1'b1; #1;
        check(mon_out == 1'b1, "R11 monitor vco high pol0", mon_out, 1);
        mon_sel = 1'b0; #1;
        check(mon_out == lock_o, "R11 monitor shows lock", mon_out, lock_o);
        vco_in = 1'b0; pol = 1'b1; #1;
        repeat (2) @(negedge clk);

        // force-off: R6 R5
        zc_n = 1'b0;
        run_pair(3);
        check(hi_c == 0, "R6 no drive while forced off", hi_c, 0);
        check(up_c == 0, "R6 no enable while forced off", up_c, 0);
        check(phr_c == 3, "R5 phr independent of force-off", phr_c, 3);
        zc_n = 1'b1;

        // power save: R7 R8
        reset_dut();
        ps_n = 1'b0; #1;
        check(lock_o == 1'b1, "R7 lock forced at once", lock_o, 1);
        run_pair(5);
        check(hi_c == 0, "R7 no drive in power save", hi_c, 0);
        check(phr_c == 0, "R7 detector cleared in power save", phr_c, 0);
        check(lock_o == 1'b1, "R7 lock held in power save", lock_o, 1);
        ps_n = 1'b1;
        repeat (2) @(negedge clk);
        run_pair(6);
        check(hi_c == 3, "R8 first pulse clipped", hi_c, 3);
        check(phr_c == 3, "R8 phr clipped", phr_c, 3);
        check(lock_o == 1'b0, "R9 lock drops after wake", lock_o, 0);
        run_pair(6);
        check(hi_c == 6, "R8 later pulse not clipped", hi_c, 6);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule